// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Datapath

This block is a synthesizable behavioural model of a synchronous static memory built so that a shared data bus never needs an idle cycle when it turns from reads to writes. Each cycle it takes an operation that has already been decoded (read, byte-masked write or no-op) along with an address. It then places read data on the bus and takes write data off the bus at fixed clock offsets. The write offset equals the read offset, so a stream of mixed reads and writes keeps the bus busy on every cycle.

The data bus is split into 9-bit byte lanes, and each lane has its own active-low write strobe. A static mode pin selects one of two timings. In pipelined timing, read data passes through an output register and write data arrives two edges after its command. In flow-through timing, read data comes straight from the array and write data arrives one edge after its command. The bus appears as a data-in vector, a data-out vector and a drive-enable flag. The block also handles a clock-enable stall, an asynchronous output enable, and a sleep input with a recovery window after it.

Top module: `lwsram_core`

## Requirements
- R1: Once reset is released, `dq_drive` stays low until read data is scheduled onto the bus for the first time.
- R2: In pipelined timing (`flow_sel_n` = 1), suppose a read (`cmd_op` = 2'b01) is taken on edge E. Then its data is driven from just after edge E+1 until edge E+2.
- R3: In flow-through timing (`flow_sel_n` = 0), suppose a read is taken on edge E. Then its data is driven from just after edge E until edge E+1.
- R4: In pipelined timing, suppose a write (`cmd_op` = 2'b10) is taken on edge E. Then its data is sampled from `dq_i` on edge E+2.
- R5: In flow-through timing, suppose a write is taken on edge E. Then its data is sampled from `dq_i` on edge E+1.
- R6: When `cmd_be_n[i]` is 0, lane i (bits 9i+8..9i) is written, and a lane whose strobe is 1 keeps its old contents. A write with every strobe at 1 does nothing.
- R7: Reads and writes may alternate on consecutive edges. `dq_drive` stays low in every cycle that carries write data.
- R8: An edge taken while `clk_en_n` = 1 changes no state and ignores the command. A read already on the bus keeps driving, and no write data is sampled.
- R9: While `oe_n` = 1, `dq_drive` is low in the same cycle, and internal state is left as it was.
- R10: If `sleep_req` is sampled high on two consecutive edges, then from the second of those edges the bus is undriven, commands are ignored and memory contents are kept.
- R11: Once sleep ends, writes are dropped for `WAKE_CYC` edges while reads are still served.
- R12: In pipelined timing, a read that hits the address of a write whose data has not yet been committed returns that write's data in the strobed lanes and array data in the other lanes.
- R13: `flow_sel_n` low selects flow-through timing, and high selects pipelined timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the block |
| sleep_req | input | 1 | Sleep request, active high |
| flow_sel_n | input | 1 | Timing select: 0 flow-through, 1 pipelined |
| oe_n | input | 1 | Asynchronous active-low output enable |
| cmd_op | input | 2 | Operation: 00 no-op, 01 read, 10 write, 11 no-op |
| cmd_addr | input | AW | Word address |
| cmd_be_n | input | LANES | Active-low per-lane write strobes |
| dq_i | input | DW | Data arriving from the shared bus |
| dq_o | output | DW | Data to drive onto the shared bus |
| dq_drive | output | 1 | High when the block drives the bus |

## Verification
The bound checker tests a set of bus-level invariants on every clock. The bus is never driven while output enable is high. It is never driven in a cycle whose write data is being committed. The output data holds steady across a stalled edge. The bus is undriven once sleep has taken effect. No commit ever happens with all strobes inactive. Behaviour that needs memory across many cycles can only be shown by the bench scenarios, which compare against a queue-based reference model. This covers the exact read and write offsets in both timings, byte-lane merging, the bypass when a read follows a write, the dropping of writes during wake recovery, and contents kept through sleep.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

   // Decoded operation presented on cmd_op
   typedef enum logic [1:0] {
      OP_NOP = 2'b00,
      OP_RD  = 2'b01,
      OP_WR  = 2'b10
   } op_e;

   // Contents of one command slot in the late-write pipe
   typedef enum logic [1:0] {
      SLOT_IDLE = 2'b00,
      SLOT_RD   = 2'b01,
      SLOT_WR   = 2'b10
   } slot_e;

endpackage

// File: rtl/lwsram_sleep_ctl.sv
module lwsram_sleep_ctl #(
   parameter  int WAKE_CYC = 4,
   localparam int WCW      = $clog2(WAKE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   output logic asleep,
   output logic wake_busy
);

   // two-stage delay: sleep takes effect on the second sampled edge
   logic [1:0]     dly_q;
   logic [WCW-1:0] wake_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_q <= '0;
      end else begin
         dly_q <= {dly_q[0], sleep_req};
      end
   end

   assign asleep = dly_q[1];

   // recovery window: reloaded while asleep, drains once awake
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_cnt_q <= '0;
      end else if (asleep) begin
         wake_cnt_q <= WCW'(WAKE_CYC);
      end else if (wake_cnt_q != '0) begin
         wake_cnt_q <= wake_cnt_q - WCW'(1);
      end
   end

   assign wake_busy = (wake_cnt_q != '0);

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
   parameter  int LANES  = 2,
   parameter  int LANE_W = 9,
   parameter  int DEPTH  = 16,
   localparam int DW     = LANES * LANE_W,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    wr_addr,
   input  logic [LANES-1:0] wr_lane_n,
   input  logic [DW-1:0]    wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_data
);

   logic [DW-1:0] store [DEPTH];
   logic [DW-1:0] bit_mask;

   // widen each active-low lane strobe into a bit mask
   for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign bit_mask[l*LANE_W +: LANE_W] = {LANE_W{~wr_lane_n[l]}};
   end

   always_ff @(posedge clk) begin
      if (we) begin
         store[wr_addr] <= (store[wr_addr] & ~bit_mask) | (wr_data & bit_mask);
      end
   end

   assign rd_data = store[rd_addr];

endmodule

// File: rtl/lwsram_lane_merge.sv
module lwsram_lane_merge #(
   parameter  int LANES  = 2,
   parameter  int LANE_W = 9,
   localparam int DW     = LANES * LANE_W
) (
   input  logic             hit,
   input  logic [LANES-1:0] lane_n,
   input  logic [DW-1:0]    stored,
   input  logic [DW-1:0]    fresh,
   output logic [DW-1:0]    merged
);

   // each lane comes from the in-flight write only when it is strobed
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*LANE_W +: LANE_W] = (hit && !lane_n[l]) ? fresh[l*LANE_W +: LANE_W]
                                                               : stored[l*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
   import lwsram_pkg::*;
#(
   parameter  int LANES    = 2,
   parameter  int LANE_W   = 9,
   parameter  int DEPTH    = 16,
   parameter  int WAKE_CYC = 4,
   localparam int DW       = LANES * LANE_W,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en_n,
   input  logic             sleep_req,
   input  logic             flow_sel_n,
   input  logic             oe_n,
   input  logic [1:0]       cmd_op,
   input  logic [AW-1:0]    cmd_addr,
   input  logic [LANES-1:0] cmd_be_n,
   input  logic [DW-1:0]    dq_i,
   output logic [DW-1:0]    dq_o,
   output logic             dq_drive
);

   // elaboration-time parameter checks
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("lwsram_core: LANES and LANE_W must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lwsram_core: DEPTH must be a power of two of at least 2");
   end
   if (WAKE_CYC < 1) begin : g_bad_wake
      $error("lwsram_core: WAKE_CYC must be at least 1");
   end

   logic asleep;
   logic wake_busy;
   logic adv;
   logic flow;

   slot_e            new_kind;
   slot_e            s1_kind, s2_kind;
   logic [AW-1:0]    s1_addr, s2_addr;
   logic [LANES-1:0] s1_be_n, s2_be_n;

   logic             wr_commit;
   logic [AW-1:0]    commit_addr;
   logic [LANES-1:0] commit_be_n;

   logic [DW-1:0]    rd_raw;
   logic [DW-1:0]    rd_merged;
   logic             byp_hit;

   logic             oreg_v;
   logic [DW-1:0]    oreg_d;

   lwsram_sleep_ctl #(.WAKE_CYC(WAKE_CYC)) u_sleep (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .asleep    (asleep),
      .wake_busy (wake_busy)
   );

   assign adv  = !clk_en_n && !asleep;
   assign flow = !flow_sel_n;

   // R6/R11: a write with no strobes, or one issued during recovery, becomes an idle slot
   always_comb begin
      new_kind = SLOT_IDLE;
      if (cmd_op == OP_RD) begin
         new_kind = SLOT_RD;
      end else if (cmd_op == OP_WR && !(&cmd_be_n) && !wake_busy) begin
         new_kind = SLOT_WR;
      end
   end

   // command slots: s1 holds the op registered last edge, s2 the one before
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_kind <= SLOT_IDLE;
         s2_kind <= SLOT_IDLE;
         s1_addr <= '0;
         s2_addr <= '0;
         s1_be_n <= '1;
         s2_be_n <= '1;
      end else if (adv) begin
         s1_kind <= new_kind;
         s1_addr <= cmd_addr;
         s1_be_n <= cmd_be_n;
         s2_kind <= s1_kind;
         s2_addr <= s1_addr;
         s2_be_n <= s1_be_n;
      end
   end

   // single late write takes data one edge on, double late write two edges on
   assign commit_addr = flow ? s1_addr : s2_addr;
   assign commit_be_n = flow ? s1_be_n : s2_be_n;
   assign wr_commit   = adv && (flow ? (s1_kind == SLOT_WR) : (s2_kind == SLOT_WR));

   lwsram_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_array (
      .clk       (clk),
      .we        (wr_commit),
      .wr_addr   (commit_addr),
      .wr_lane_n (commit_be_n),
      .wr_data   (dq_i),
      .rd_addr   (s1_addr),
      .rd_data   (rd_raw)
   );

   // R12: the pipelined capture edge is also the commit edge of the preceding write
   assign byp_hit = !flow && (s2_kind == SLOT_WR) && (s2_addr == s1_addr);

   lwsram_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
      .hit    (byp_hit),
      .lane_n (s2_be_n),
      .stored (rd_raw),
      .fresh  (dq_i),
      .merged (rd_merged)
   );

   // output register used in pipelined timing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oreg_v <= 1'b0;
         oreg_d <= '0;
      end else if (adv) begin
         oreg_v <= (s1_kind == SLOT_RD);
         if (s1_kind == SLOT_RD) begin
            oreg_d <= rd_merged;
         end
      end
   end

   assign dq_o     = flow ? rd_raw : oreg_d;
   assign dq_drive = !oe_n && !asleep && (flow ? (s1_kind == SLOT_RD) : oreg_v);

endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk #(
   parameter  int LANES  = 2,
   parameter  int LANE_W = 9,
   localparam int DW     = LANES * LANE_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clk_en_n,
   input logic             sleep_req,
   input logic             oe_n,
   input logic [DW-1:0]    dq_o,
   input logic             dq_drive,
   input logic             wr_commit,
   input logic [LANES-1:0] commit_be_n
);

   // R9
   oe_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_drive);

   // R7
   no_drive_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> !dq_drive);

   // R8
   stall_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(dq_o));

   // R10
   sleep_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req ##1 sleep_req |=> !dq_drive);

   // R6
   commit_has_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> !(&commit_be_n));

endmodule

bind lwsram_core lwsram_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clk_en_n    (clk_en_n),
   .sleep_req   (sleep_req),
   .oe_n        (oe_n),
   .dq_o        (dq_o),
   .dq_drive    (dq_drive),
   .wr_commit   (wr_commit),
   .commit_be_n (commit_be_n)
);

// File: tb/lwsram_core_tb.sv
module lwsram_core_tb;

   localparam int  LANES    = 2;
   localparam int  LANE_W   = 9;
   localparam int  DEPTH    = 16;
   localparam int  WAKE_CYC = 4;
   localparam int  DW       = LANES * LANE_W;
   localparam int  AW       = $clog2(DEPTH);
   localparam time CYC      = 20ns;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             clk_en_n;
   logic             sleep_req;
   logic             flow_sel_n;
   logic             oe_n;
   logic [1:0]       cmd_op;
   logic [AW-1:0]    cmd_addr;
   logic [LANES-1:0] cmd_be_n;
   logic [DW-1:0]    dq_i;
   logic [DW-1:0]    dq_o;
   logic             dq_drive;

   always #(CYC/2) clk = ~clk;

   lwsram_core #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH), .WAKE_CYC(WAKE_CYC)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_en_n   (clk_en_n),
      .sleep_req  (sleep_req),
      .flow_sel_n (flow_sel_n),
      .oe_n       (oe_n),
      .cmd_op     (cmd_op),
      .cmd_addr   (cmd_addr),
      .cmd_be_n   (cmd_be_n),
      .dq_i       (dq_i),
      .dq_o       (dq_o),
      .dq_drive   (dq_drive)
   );

   // ---------------- reference model ----------------
   typedef struct packed {
      logic             wr;
      logic [AW-1:0]    addr;
      logic [LANES-1:0] be_n;
      logic [1:0]       rem;
   } ent_t;

   ent_t          pend[$];
   logic [DW-1:0] m_mem [DEPTH];
   logic          m_pv, m_fv, m_sl1, m_sl2;
   logic [DW-1:0] m_pd;
   logic [AW-1:0] m_fa;
   int            m_wake;

   int    n_chk  = 0;
   int    n_fail = 0;
   int    cyc    = 0;
   bit    done   = 0;
   string tag    = "R1";

   task automatic model_reset();
      pend.delete();
      m_pv = 0; m_fv = 0; m_sl1 = 0; m_sl2 = 0; m_wake = 0; m_pd = '0; m_fa = '0;
   endtask

   task automatic model_edge();
      bit   was_asleep;
      bit   go;
      bit   flow;
      ent_t keep[$];
      was_asleep = m_sl2;
      go   = !clk_en_n && !was_asleep;
      flow = !flow_sel_n;
      if (go) begin
         foreach (pend[i]) pend[i].rem = pend[i].rem - 2'd1;
         // writes land first so a read captured on the same edge sees them
         foreach (pend[i]) begin
            if (pend[i].rem == 0 && pend[i].wr) begin
               for (int l = 0; l < LANES; l++) begin
                  if (!pend[i].be_n[l])
                     m_mem[pend[i].addr][l*LANE_W +: LANE_W] = dq_i[l*LANE_W +: LANE_W];
               end
            end
         end
         m_pv = 0;
         foreach (pend[i]) begin
            if (pend[i].rem == 0 && !pend[i].wr) begin
               m_pv = 1;
               m_pd = m_mem[pend[i].addr];
            end
         end
         foreach (pend[i]) if (pend[i].rem != 0) keep.push_back(pend[i]);
         pend = keep;
         m_fv = 0;
         if (cmd_op == 2'b01) begin
            if (flow) begin
               m_fv = 1;
               m_fa = cmd_addr;
            end else begin
               pend.push_back('{wr: 1'b0, addr: cmd_addr, be_n: '1, rem: 2'd1});
            end
         end else if (cmd_op == 2'b10 && cmd_be_n != '1 && m_wake == 0) begin
            pend.push_back('{wr: 1'b1, addr: cmd_addr, be_n: cmd_be_n, rem: (flow ? 2'd1 : 2'd2)});
         end
      end
      if (was_asleep) m_wake = WAKE_CYC;
      else if (m_wake > 0) m_wake = m_wake - 1;
      m_sl2 = m_sl1;
      m_sl1 = sleep_req;
   endtask

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s cyc=%0d act=%0h exp=%0h", tag, what, cyc, act, exp);
      end
   endtask

   task automatic compare();
      bit            flow;
      bit            exp_drv;
      logic [DW-1:0] exp_d;
      flow    = !flow_sel_n;
      exp_drv = !oe_n && !m_sl2 && (flow ? m_fv : m_pv);
      exp_d   = flow ? m_mem[m_fa] : m_pd;
      chk("drive", 32'(dq_drive), 32'(exp_drv));
      if (exp_drv) chk("data", 32'(dq_o), 32'(exp_d));
   endtask

   task automatic tick(input logic [1:0] op, input int addr, input logic [LANES-1:0] ben);
      cmd_op   = op;
      cmd_addr = AW'(addr);
      cmd_be_n = ben;
      dq_i     = DW'(cyc * 7919 + 123);
      @(posedge clk);
      model_edge();
      #5;
      compare();
      @(negedge clk);
      cyc++;
   endtask

   task automatic nops(input int n);
      for (int k = 0; k < n; k++) tick(2'b00, 0, '1);
   endtask

   task automatic do_reset(input logic fsel);
      rst_n = 1'b0; flow_sel_n = fsel; clk_en_n = 1'b0; oe_n = 1'b0; sleep_req = 1'b0;
      cmd_op = 2'b00; cmd_addr = '0; cmd_be_n = '1; dq_i = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      tag = "R1";
      #1;
      chk("drive after reset", 32'(dq_drive), 32'd0);
      nops(3);
   endtask

   task automatic run_mode(input logic fsel);
      do_reset(fsel);
      // fill every word
      tag = fsel ? "R4" : "R5";
      for (int a = 0; a < DEPTH; a++) tick(2'b10, a, '0);
      nops(2);
      tag = fsel ? "R2/R13" : "R3/R13";
      for (int a = 0; a < DEPTH; a++) tick(2'b01, a, '1);
      nops(2);
      // alternate read and write on every edge
      tag = "R7";
      for (int i = 0; i < 10; i++) tick((i % 2 == 0) ? 2'b01 : 2'b10, i, '0);
      nops(3);
      // lane strobes, including the all-inactive no-op
      tag = "R6";
      tick(2'b10, 3, 2'b10);
      tick(2'b10, 4, 2'b01);
      tick(2'b10, 5, 2'b11);
      nops(2);
      tick(2'b01, 3, '1);
      tick(2'b01, 4, '1);
      tick(2'b01, 5, '1);
      nops(2);
      // read right behind a write to the same word
      tag = "R12";
      tick(2'b10, 7, 2'b01);
      tick(2'b01, 7, '1);
      tick(2'b10, 8, 2'b00);
      tick(2'b01, 8, '1);
      nops(3);
      // stall with a read on the bus, then with a write in flight
      tag = "R8";
      tick(2'b01, 2, '1);
      tick(2'b00, 0, '1);
      clk_en_n = 1'b1;
      tick(2'b01, 9, '1);
      tick(2'b10, 9, '0);
      tick(2'b00, 0, '1);
      clk_en_n = 1'b0;
      nops(2);
      tick(2'b10, 10, '0);
      clk_en_n = 1'b1;
      nops(3);
      clk_en_n = 1'b0;
      nops(3);
      tick(2'b01, 10, '1);
      tick(2'b01, 9, '1);
      nops(2);
      // asynchronous output enable
      tag = "R9";
      tick(2'b01, 1, '1);
      tick(2'b00, 0, '1);
      oe_n = 1'b1;
      #1 compare();
      tick(2'b01, 1, '1);
      oe_n = 1'b0;
      #1 compare();
      nops(2);
      // sleep: entry delay, ignored commands, kept contents
      tag = "R10";
      tick(2'b01, 2, '1);
      sleep_req = 1'b1;
      tick(2'b01, 3, '1);
      tick(2'b00, 0, '1);
      for (int k = 0; k < 4; k++) tick(2'b10, 6, '0);
      tick(2'b01, 6, '1);
      sleep_req = 1'b0;
      nops(1);
      // recovery window drops writes, serves reads
      tag = "R11";
      for (int k = 0; k < WAKE_CYC + 3; k++) tick((k % 2 == 0) ? 2'b10 : 2'b01, 11 + (k % 3), '0);
      nops(3);
      for (int a = 11; a < 14; a++) tick(2'b01, a, '1);
      tick(2'b01, 6, '1);
      nops(3);
   endtask

   initial begin
      do_reset(1'b1);
      run_mode(1'b1);
      run_mode(1'b0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CYC * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R1 act=hung exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule